// File: doc/BRIEF.md
# Transmit Descriptor Fetch and Status Engine

This block moves outgoing frames from memory to a byte stream. Software builds a ring of two-word descriptors in memory, each pointing at a word-aligned buffer and giving its byte count and flags. It writes the ring's start address into the queue base register, sets the transmitter enable bit and then issues a start command. The engine walks the ring from its current descriptor and reads each buffer one 32-bit word at a time. It sends the bytes lowest-address first on a valid/ready byte port and keeps going until it has consumed a buffer flagged as the end of a frame. It then sets the used bit in the frame's first descriptor, raises a completion flag and returns to idle.

A fetched descriptor that is already marked used, a bus error response, or a buffer read that stalls after bytes have left ends the walk. Each of these errors is recorded in a transmit status register. Software clears its bits by writing ones. Clearing the enable bit aborts any frame in flight and holds the descriptor pointer at the queue base.

The controller has six named states. IDLE waits for a start. DESC_ADDR fetches word 0. DESC_CTRL fetches word 1. BUF_RD reads a buffer word. STREAM hands out that word's bytes. MARK writes the used bit back. The transitions are:
- IDLE to DESC_ADDR on an accepted start.
- DESC_ADDR to DESC_CTRL on an ack.
- DESC_CTRL to BUF_RD when the buffer is non-empty.
- DESC_CTRL to DESC_ADDR when the buffer is empty and not last.
- DESC_CTRL to MARK when the buffer is empty and last.
- DESC_CTRL to IDLE when the descriptor is used.
- BUF_RD to STREAM on an ack.
- STREAM to BUF_RD when the word is spent and bytes remain.
- STREAM to DESC_ADDR when a non-last buffer is spent.
- STREAM to MARK when a last buffer is spent.
- MARK to IDLE on the write ack.
- Any state to IDLE on a bus error, an underrun, or the enable bit going low.

Top module: `txd_engine_top`

## Requirements
- R1: After reset the status register reads 0, the control register reads 0, and both tx_valid and mem_req are low.
- R2: A control write with bit 9 set starts a walk only when the enable bit (control bit 3) is already 1 and the engine is idle. A start at any other time has no effect.
- R3: Word 0 of a descriptor is the buffer address (word aligned). Bits 13:0 of word 1 are the byte count. The bytes go out in rising address order, byte 0 of each memory word first. A count of zero contributes no bytes.
- R4: A frame covers successive buffers up to and including the one whose word 1 bit 15 is set. tx_last is high only on the final byte of that buffer.
- R5: The next descriptor lies 8 bytes after the current one, except after a descriptor with word 1 bit 30 set, when it is the queue base.
- R6: On frame completion the engine writes the first descriptor's word 1 back with bit 31 set and the other bits unchanged. It also sets status bit 5.
- R7: If the first descriptor fetched for a new frame has bit 31 set, the engine returns to idle with no status flag and without moving the pointer.
- R8: If a later descriptor of a frame has bit 31 set, status bit 4 is set, the frame ends without tx_last and the pointer returns to the base.
- R9: A memory error response sets status bit 8, ends the frame and returns the pointer to the base.
- R10: A buffer word read that has waited UNDER_LIMIT cycles, after at least one byte of the frame has been sent, sets status bit 6, ends the frame and returns the pointer to the base.
- R11: A write to the status register (address 1) clears each bit that is 1 in the written data and leaves the others. A flag raised in the same cycle stays set.
- R12: Clearing the enable bit aborts a frame in flight, leaves the first descriptor unmarked and holds the pointer at the queue base.
- R13: A write to the queue base register (address 2), made while idle, moves the pointer to that address.
- R14: While tx_valid is high and tx_ready low, tx_data and tx_last hold. A memory request holds its address and direction until mem_ack or mem_err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 status, 2 queue base |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Memory byte address (word aligned) |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request completed |
| mem_err | input | 1 | Request ended with an error response |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| tx_valid | output | 1 | Byte available |
| tx_data | output | 8 | Byte value |
| tx_last | output | 1 | Final byte of the frame |
| tx_ready | input | 1 | Sink accepts the byte |

## Verification
The assertions assume a well-behaved memory. It raises mem_ack or mem_err only while mem_req is high, and at most one of them per cycle. They also assume the queue base is rewritten only when the engine is idle. The bench's memory model answers only a live request after a programmable latency, and reports an error only on one chosen address. Register writes to the base are issued only after the engine has gone quiet, and the sink changes tx_ready freely, since the stream rules hold for any ready pattern.

// File: rtl/txd_pkg.sv
package txd_pkg;
    localparam int WORD_W  = 32;
    localparam int CNT_W   = 14;
    // descriptor word-1 flags
    localparam int USED_B  = 31;
    localparam int WRAP_B  = 30;
    localparam int EOF_B   = 15;
    // control bits
    localparam int CTL_EN  = 3;
    localparam int CTL_GO  = 9;
    // status bits
    localparam int ST_EXH  = 4;
    localparam int ST_DONE = 5;
    localparam int ST_URUN = 6;
    localparam int ST_BERR = 8;
    // register selects
    localparam logic [1:0] RA_CTRL  = 2'd0;
    localparam logic [1:0] RA_STAT  = 2'd1;
    localparam logic [1:0] RA_QBASE = 2'd2;

    typedef enum logic [2:0] {
        S_IDLE, S_DESC_ADDR, S_DESC_CTRL, S_BUF_RD, S_STREAM, S_MARK
    } txd_state_e;
endpackage

// File: rtl/txd_regs.sv
module txd_regs
    import txd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata,
    input  logic              set_exh,
    input  logic              set_done,
    input  logic              set_urun,
    input  logic              set_berr,
    output logic              en_q,
    output logic              go,
    output logic [WORD_W-1:0] qbase_q,
    output logic              qbase_load
);
    localparam logic [WORD_W-1:0] ST_MASK =
        (WORD_W'(1) << ST_EXH) | (WORD_W'(1) << ST_DONE) |
        (WORD_W'(1) << ST_URUN) | (WORD_W'(1) << ST_BERR);

    logic [WORD_W-1:0] status_q, set_vec, clr_vec;

    always_comb begin
        set_vec = '0;
        set_vec[ST_EXH]  = set_exh;
        set_vec[ST_DONE] = set_done;
        set_vec[ST_URUN] = set_urun;
        set_vec[ST_BERR] = set_berr;
        clr_vec = (wr_en && addr == RA_STAT) ? (wdata & ST_MASK) : '0;
    end

    assign go = wr_en && addr == RA_CTRL && wdata[CTL_GO] && en_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q   <= '0;
            en_q       <= 1'b0;
            qbase_q    <= '0;
            qbase_load <= 1'b0;
        end else begin
            status_q   <= (status_q & ~clr_vec) | set_vec;
            qbase_load <= wr_en && addr == RA_QBASE;
            if (wr_en && addr == RA_CTRL)  en_q    <= wdata[CTL_EN];
            if (wr_en && addr == RA_QBASE) qbase_q <= {wdata[WORD_W-1:3], 3'b000};
        end
    end

    always_comb begin
        unique case (addr)
            RA_CTRL:  rdata = WORD_W'(en_q) << CTL_EN;
            RA_STAT:  rdata = status_q;
            RA_QBASE: rdata = qbase_q;
            default:  rdata = '0;
        endcase
    end

    // R11: a written one clears the bit unless raised in the same cycle
    assert_w1c_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == RA_STAT && wdata[ST_BERR] && !set_berr)
        |=> !status_q[ST_BERR]);
    // R11: a raised flag is visible next cycle whatever is written
    assert_flag_sticks_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_vec) |=> ((status_q & $past(set_vec)) == $past(set_vec)));
endmodule

// File: rtl/txd_walker.sv
module txd_walker
    import txd_pkg::*;
#(
    parameter int UNDER_LIMIT = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_q,
    input  logic              go,
    input  logic [WORD_W-1:0] qbase,
    input  logic              qbase_load,
    output logic              mem_req,
    output logic              mem_we,
    output logic [WORD_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic              mem_err,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              tx_ready,
    output logic              stream_act,
    output logic              final_byte,
    output logic [WORD_W-1:0] word_q,
    output logic [1:0]        bidx_q,
    output logic              set_exh,
    output logic              set_done,
    output logic              set_urun,
    output logic              set_berr
);
    localparam int WCW = $clog2(UNDER_LIMIT + 1);

    txd_state_e        st, st_n;
    logic [WORD_W-1:0] ptr, first_ptr, buf_addr, first_w1;
    logic [CNT_W-1:0]  rem;
    logic              is_eof, is_wrap, in_frame, sent_any;
    logic [WCW-1:0]    wait_cnt;
    logic              fire, wait_hit, abort;
    logic [WORD_W-1:0] next_ptr_d, next_ptr_s;

    assign fire       = stream_act && tx_ready;
    assign wait_hit   = st == S_BUF_RD && sent_any && !mem_ack && !mem_err &&
                        wait_cnt == WCW'(UNDER_LIMIT - 1);
    assign next_ptr_d = mem_rdata[WRAP_B] ? qbase : ptr + WORD_W'(8);
    assign next_ptr_s = is_wrap ? qbase : ptr + WORD_W'(8);
    assign abort      = set_exh || set_urun || set_berr;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= st_n;
    end

    // next state and flag pulses
    always_comb begin
        st_n = st;
        {set_exh, set_done, set_urun, set_berr} = '0;
        if (!en_q) begin
            st_n = S_IDLE;
        end else begin
            unique case (st)
                S_IDLE: if (go) st_n = S_DESC_ADDR;
                S_DESC_ADDR: begin
                    if (mem_err) begin set_berr = 1'b1; st_n = S_IDLE; end
                    else if (mem_ack) st_n = S_DESC_CTRL;
                end
                S_DESC_CTRL: begin
                    if (mem_err) begin set_berr = 1'b1; st_n = S_IDLE; end
                    else if (mem_ack) begin
                        if (mem_rdata[USED_B]) begin
                            set_exh = in_frame;
                            st_n    = S_IDLE;
                        end else if (mem_rdata[CNT_W-1:0] != '0) st_n = S_BUF_RD;
                        else if (mem_rdata[EOF_B])               st_n = S_MARK;
                        else                                      st_n = S_DESC_ADDR;
                    end
                end
                S_BUF_RD: begin
                    if (mem_err)       begin set_berr = 1'b1; st_n = S_IDLE; end
                    else if (mem_ack)  st_n = S_STREAM;
                    else if (wait_hit) begin set_urun = 1'b1; st_n = S_IDLE; end
                end
                S_STREAM: begin
                    if (fire) begin
                        if (rem == CNT_W'(1)) st_n = is_eof ? S_MARK : S_DESC_ADDR;
                        else if (bidx_q == 2'd3) st_n = S_BUF_RD;
                    end
                end
                S_MARK: begin
                    if (mem_err)      begin set_berr = 1'b1; st_n = S_IDLE; end
                    else if (mem_ack) begin set_done = 1'b1; st_n = S_IDLE; end
                end
                default: st_n = S_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        mem_req    = en_q && st != S_IDLE && st != S_STREAM;
        mem_we     = st == S_MARK;
        mem_wdata  = first_w1 | (WORD_W'(1) << USED_B);
        stream_act = en_q && st == S_STREAM;
        final_byte = rem == CNT_W'(1) && is_eof;
        unique case (st)
            S_DESC_ADDR: mem_addr = ptr;
            S_DESC_CTRL: mem_addr = ptr + WORD_W'(4);
            S_BUF_RD:    mem_addr = buf_addr;
            S_MARK:      mem_addr = first_ptr + WORD_W'(4);
            default:     mem_addr = ptr;
        endcase
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr <= '0; first_ptr <= '0; buf_addr <= '0; first_w1 <= '0;
            word_q <= '0; rem <= '0; bidx_q <= '0; wait_cnt <= '0;
            is_eof <= 1'b0; is_wrap <= 1'b0; in_frame <= 1'b0; sent_any <= 1'b0;
        end else begin
            wait_cnt <= (st == S_BUF_RD && !mem_ack && !mem_err) ? wait_cnt + WCW'(1) : '0;
            if (!en_q || qbase_load || abort) ptr <= qbase;
            if (!en_q || abort) begin
                in_frame <= 1'b0;
                sent_any <= 1'b0;
            end else begin
                unique case (st)
                    S_DESC_ADDR: if (mem_ack) buf_addr <= {mem_rdata[WORD_W-1:2], 2'b00};
                    S_DESC_CTRL: if (mem_ack && !mem_rdata[USED_B]) begin
                        rem      <= mem_rdata[CNT_W-1:0];
                        is_eof   <= mem_rdata[EOF_B];
                        is_wrap  <= mem_rdata[WRAP_B];
                        bidx_q   <= '0;
                        in_frame <= 1'b1;
                        if (!in_frame) begin
                            first_ptr <= ptr;
                            first_w1  <= mem_rdata;
                        end
                        if (mem_rdata[CNT_W-1:0] == '0) ptr <= next_ptr_d;
                    end
                    S_BUF_RD: if (mem_ack) word_q <= mem_rdata;
                    S_STREAM: if (fire) begin
                        rem      <= rem - CNT_W'(1);
                        bidx_q   <= bidx_q + 2'd1;
                        sent_any <= 1'b1;
                        if (rem == CNT_W'(1))  ptr      <= next_ptr_s;
                        else if (bidx_q == 2'd3) buf_addr <= buf_addr + WORD_W'(4);
                    end
                    S_MARK: if (mem_ack) begin
                        in_frame <= 1'b0;
                        sent_any <= 1'b0;
                    end
                    default: ;
                endcase
            end
        end
    end

    // R14: a pending request keeps its address and direction
    assert_req_hold_R14: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack && !mem_err && !wait_hit)
        |=> (!en_q || (mem_req && $stable(mem_addr) && $stable(mem_we))));
    // R8 R9 R10 R6: one outcome is reported per cycle
    assert_one_outcome_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({set_exh, set_done, set_urun, set_berr}));
    // R2: nothing reaches memory while the transmitter is disabled
    assert_quiet_when_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |-> (!mem_req && !stream_act));
endmodule

// File: rtl/txd_lane.sv
module txd_lane
    import txd_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    input  logic [1:0]        idx,
    input  logic              active,
    input  logic              final_byte,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    output logic              tx_last
);
    localparam int NB = WORD_W / 8;
    logic [7:0] lanes [NB];

    for (genvar b = 0; b < NB; b++) begin : g_lane
        assign lanes[b] = word[8*b +: 8];
    end

    assign tx_valid = active;
    assign tx_data  = lanes[idx];
    assign tx_last  = active && final_byte;
endmodule

// File: rtl/txd_engine_top.sv
module txd_engine_top
    import txd_pkg::*;
#(
    parameter int UNDER_LIMIT = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic        mem_ack,
    input  logic        mem_err,
    input  logic [31:0] mem_rdata,
    output logic        tx_valid,
    output logic [7:0]  tx_data,
    output logic        tx_last,
    input  logic        tx_ready
);
    logic              en_q, go, qbase_load, stream_act, final_byte;
    logic [WORD_W-1:0] qbase_q, word_q;
    logic [1:0]        bidx_q;
    logic              set_exh, set_done, set_urun, set_berr;

    txd_regs u_regs (
        .clk, .rst_n, .wr_en(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
        .rdata(reg_rdata), .set_exh, .set_done, .set_urun, .set_berr,
        .en_q, .go, .qbase_q, .qbase_load
    );

    txd_walker #(.UNDER_LIMIT(UNDER_LIMIT)) u_walk (
        .clk, .rst_n, .en_q, .go, .qbase(qbase_q), .qbase_load,
        .mem_req, .mem_we, .mem_addr, .mem_wdata, .mem_ack, .mem_err, .mem_rdata,
        .tx_ready, .stream_act, .final_byte, .word_q, .bidx_q,
        .set_exh, .set_done, .set_urun, .set_berr
    );

    txd_lane u_lane (
        .word(word_q), .idx(bidx_q), .active(stream_act), .final_byte,
        .tx_valid, .tx_data, .tx_last
    );

    // R14: an offered byte stays put until taken or the frame is aborted
    assert_stream_hold_R14: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready)
        |=> (!tx_valid && !u_regs.en_q) || (tx_valid && $stable(tx_data) && $stable(tx_last)));
    // R4: tx_last appears only on an offered byte
    assert_last_with_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_last |-> tx_valid);
endmodule

// File: tb/sim_txd_engine_top.sv
`timescale 1ns/1ps
module sim_txd_engine_top;
    logic clk = 0, rst_n = 0;
    logic reg_wr = 0; logic [1:0] reg_addr = 0; logic [31:0] reg_wdata = 0;
    logic [31:0] reg_rdata;
    logic mem_req, mem_we; logic [31:0] mem_addr, mem_wdata;
    logic mem_ack = 0, mem_err = 0; logic [31:0] mem_rdata = 0;
    logic tx_valid, tx_last; logic [7:0] tx_data; logic tx_ready = 0;

    always #5 clk = ~clk;

    txd_engine_top u0 (.*);

    logic [31:0] mem_w [0:255];
    int lat = 0, lat_cnt = 0, ready_mode = 0, cyc = 0;
    logic [31:0] err_addr = 32'hFFFF_FFFF;
    logic [7:0] rx_b [0:63]; bit rx_l [0:63]; int rx_n = 0;
    logic [7:0] exp_b [0:63]; int exp_n = 0;
    int n_chk = 0, n_fail = 0; bit done = 0;

    function automatic logic [7:0] pat(int a);
        return 8'((a * 37) ^ (a >> 3) ^ 8'h5A);
    endfunction
    function automatic logic [31:0] mkw1(int cnt, bit eof, bit wrap, bit used);
        return (32'(used) << 31) | (32'(wrap) << 30) | (32'(eof) << 15) | 32'(cnt);
    endfunction

    // memory responder and byte sink, all on the falling edge
    initial forever begin
        @(negedge clk);
        cyc++;
        mem_ack = 0; mem_err = 0;
        if (mem_req) begin
            if (lat_cnt >= lat) begin
                lat_cnt = 0;
                if (mem_addr == err_addr) mem_err = 1;
                else begin
                    mem_ack = 1;
                    if (mem_we) mem_w[mem_addr[9:2]] = mem_wdata;
                    else        mem_rdata = mem_w[mem_addr[9:2]];
                end
            end else lat_cnt++;
        end else lat_cnt = 0;
        case (ready_mode)
            0: tx_ready = 1;
            1: tx_ready = cyc[0];
            default: tx_ready = (cyc % 3 == 0);
        endcase
        if (tx_valid && tx_ready && rx_n < 64) begin
            rx_b[rx_n] = tx_data; rx_l[rx_n] = tx_last; rx_n++;
        end
    end

    task automatic chk(string tag, longint act, longint exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk); #1; reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk); #1; reg_wr = 0;
    endtask
    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk); #1; reg_addr = a; #1; d = reg_rdata;
    endtask
    task automatic wait_idle();
        int q = 0, g = 0;
        while (q < 4 && g < 3000) begin
            @(posedge clk); #1;
            if (!mem_req && !tx_valid) q++; else q = 0;
            g++;
        end
    endtask
    task automatic fresh();
        @(posedge clk); #2; rx_n = 0; exp_n = 0;
    endtask
    task automatic exp_add(int a, int n);
        for (int k = 0; k < n; k++) begin exp_b[exp_n] = pat(a + k); exp_n++; end
    endtask
    task automatic send();
        wr(2'd0, 32'h208); wait_idle();
    endtask
    task automatic sd(int a, logic [31:0] w0, logic [31:0] w1);
        mem_w[a >> 2] = w0; mem_w[(a >> 2) + 1] = w1;
    endtask
    task automatic check_frame(string tag, bit with_last);
        int mism = 0, lpos = -1;
        chk({tag, " byte count"}, rx_n, exp_n);
        for (int i = 0; i < rx_n && i < exp_n; i++) if (rx_b[i] !== exp_b[i]) mism++;
        chk({tag, " byte values"}, mism, 0);
        for (int i = 0; i < rx_n; i++) if (rx_l[i]) lpos = (lpos == -1) ? i : -2;
        chk({tag, " tx_last position"}, lpos, with_last ? exp_n - 1 : -1);
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, w1;
        for (int i = 0; i < 256; i++)
            mem_w[i] = {pat(4*i+3), pat(4*i+2), pat(4*i+1), pat(4*i)};
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R1 reset state
        rd(2'd1, v); chk("R1 status after reset", v, 0);
        rd(2'd0, v); chk("R1 control after reset", v, 0);
        chk("R1 tx_valid after reset", tx_valid, 0);
        chk("R1 mem_req after reset", mem_req, 0);

        // R2 start without enable
        fresh(); sd(0, 32'h100, mkw1(4, 1, 0, 0));
        wr(2'd0, 32'h200); repeat (20) @(posedge clk);
        chk("R2 start while disabled sends nothing", rx_n, 0);
        wr(2'd0, 32'h8);

        // R3 R4 R6 R11 sweep of length, ready pattern and latency
        for (int n = 1; n <= 9; n++) begin
            for (int m = 0; m < 3; m++) begin
                lat = n % 3; ready_mode = m;
                wr(2'd2, 0);
                w1 = mkw1(n, 1, 0, 0);
                sd(0, 32'h100 + 32*n, w1); sd(8, 32'h300, mkw1(2, 1, 1, 1));
                fresh(); exp_add(32'h100 + 32*n, n); send();
                check_frame("R3 R4 single buffer", 1);
                chk("R6 used bit written back", mem_w[1], w1 | 32'h8000_0000);
                rd(2'd1, v); chk("R6 done flag", v, 32'h20);
                wr(2'd1, 32'h20); rd(2'd1, v); chk("R11 done flag cleared", v, 0);
            end
        end
        lat = 1; ready_mode = 0;

        // R4 R3 multi-buffer frame with an empty middle buffer
        wr(2'd2, 0);
        sd(0, 32'h100, mkw1(3, 0, 0, 0)); sd(8, 32'h140, mkw1(0, 0, 0, 0));
        sd(16, 32'h180, mkw1(6, 1, 0, 0)); sd(24, 32'h1C0, mkw1(1, 1, 1, 1));
        fresh(); exp_add(32'h100, 3); exp_add(32'h180, 6); send();
        check_frame("R4 three-buffer frame", 1);
        chk("R6 first descriptor marked", mem_w[1], mkw1(3, 0, 0, 1));
        chk("R6 later descriptor untouched", mem_w[5], mkw1(6, 1, 0, 0));
        wr(2'd1, 32'h1F0);

        // R5 wrap and R7 used-at-start keeps the pointer
        wr(2'd2, 0);
        sd(0, 32'h100, mkw1(2, 1, 0, 0)); sd(8, 32'h120, mkw1(5, 1, 1, 1));
        fresh(); exp_add(32'h100, 2); send(); check_frame("R5 first of ring", 1);
        fresh(); send();
        chk("R7 used descriptor sends nothing", rx_n, 0);
        rd(2'd1, v); chk("R7 no flag on used first descriptor", v, 32'h20);
        mem_w[3] = mkw1(5, 1, 1, 0);
        fresh(); exp_add(32'h120, 5); send(); check_frame("R7 R5 pointer stayed on second", 1);
        mem_w[1] = mkw1(2, 1, 0, 0);
        fresh(); exp_add(32'h100, 2); send(); check_frame("R5 wrap back to base", 1);
        wr(2'd1, 32'h1F0);

        // R8 exhaustion mid-frame
        wr(2'd2, 0);
        sd(0, 32'h100, mkw1(5, 0, 0, 0)); sd(8, 32'h140, mkw1(2, 1, 1, 1));
        fresh(); exp_add(32'h100, 5); send(); check_frame("R8 partial frame", 0);
        rd(2'd1, v); chk("R8 exhaustion flag", v, 32'h10);
        chk("R8 first descriptor left unmarked", mem_w[1], mkw1(5, 0, 0, 0));
        mem_w[3] = mkw1(2, 1, 1, 0);
        fresh(); exp_add(32'h100, 5); exp_add(32'h140, 2); send();
        check_frame("R8 pointer back at base", 1);
        wr(2'd1, 32'h20);

        // R9 bus error on second buffer word
        wr(2'd2, 0);
        sd(0, 32'h200, mkw1(8, 1, 1, 0)); err_addr = 32'h204;
        fresh(); exp_add(32'h200, 4); send(); check_frame("R9 truncated by bus error", 0);
        err_addr = 32'hFFFF_FFFF;
        rd(2'd1, v); chk("R9 bus error flag", v, 32'h110);

        // R11 clearing one bit leaves the other
        wr(2'd1, 32'h10); rd(2'd1, v); chk("R11 selective clear", v, 32'h100);
        wr(2'd1, 32'h100); rd(2'd1, v); chk("R11 all clear", v, 0);

        // R10 underrun on a slow second read
        lat = 20;
        sd(0, 32'h200, mkw1(8, 1, 1, 0));
        fresh(); exp_add(32'h200, 4); send(); check_frame("R10 truncated by underrun", 0);
        rd(2'd1, v); chk("R10 underrun flag", v, 32'h40);
        wr(2'd1, 32'h40); lat = 0;

        // R2 start while busy is ignored
        ready_mode = 2; wr(2'd2, 0);
        sd(0, 32'h100, mkw1(9, 1, 0, 0)); sd(8, 32'h140, mkw1(3, 1, 1, 0));
        fresh(); exp_add(32'h100, 9);
        wr(2'd0, 32'h208); repeat (10) @(posedge clk); wr(2'd0, 32'h208); wait_idle();
        check_frame("R2 second start ignored", 1);
        chk("R2 next descriptor untouched", mem_w[3], mkw1(3, 1, 1, 0));
        wr(2'd1, 32'h20);

        // R12 disable aborts, pointer to base
        mem_w[1] = mkw1(9, 1, 0, 0);
        fresh(); wr(2'd0, 32'h208); repeat (8) @(posedge clk);
        wr(2'd0, 32'h0); #1;
        chk("R12 stream stopped", tx_valid, 0);
        chk("R12 memory idle", mem_req, 0);
        chk("R12 first descriptor unmarked", mem_w[1], mkw1(9, 1, 0, 0));
        ready_mode = 0; wr(2'd0, 32'h8);
        fresh(); exp_add(32'h100, 9); send(); check_frame("R12 restart from base", 1);
        wr(2'd1, 32'h20);

        // R13 base reload
        sd(32'h40, 32'h280, mkw1(4, 1, 0, 0)); sd(32'h48, 32'h2C0, mkw1(2, 1, 1, 0));
        wr(2'd2, 32'h40); rd(2'd2, v); chk("R13 base readback", v, 32'h40);
        fresh(); exp_add(32'h280, 4); send(); check_frame("R13 from new base", 1);
        mem_w[32'h44 >> 2] = mkw1(4, 1, 0, 0);
        wr(2'd2, 32'h40);
        fresh(); exp_add(32'h280, 4); send(); check_frame("R13 reload returns to base", 1);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule